// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog timer that sits on a simple 32-bit register bus. The peripheral clock is first divided by a programmable 8-bit prescaler (factor 1 to 256) and then by a selectable power of two (16, 32, 64 or 128). Each resulting divided tick decrements a 16-bit down-counter. When the counter is at zero on a tick it expires, reloads itself from the reload register, and, if the timer is armed for reset, drives a system reset pulse that lasts a fixed number of clock cycles.

Software keeps the system alive by writing a fresh value to the counter register before it expires. The reload register can only be changed while the timer is stopped, so a runaway program cannot stretch the timeout while it runs. Clearing the run bit stops the timer where it stands: the counter and both divider stages hold their state.

Top module: `wdog_timer`

## Requirements
- R1: After reset the control register reads 0x0000_0000, the reload register and the counter register both read 0x0000_FFFF, and the reset output is low.
- R2: Registers sit at byte address 0x0 (control), 0x4 (reload) and 0x8 (counter). Control fields: bit 0 run, bit 1 reset-arm, bits 5:4 divide select, bits 15:8 prescaler value; all other control bits read 0. Read data appears on the bus one clock after the read strobe.
- R3: A write to the reload register while the run bit is 1 is ignored; while run is 0 it takes effect.
- R4: A write to the counter register loads the written value into the counter at once, whether or not the timer runs.
- R5: While running, one divided tick occurs every (P+1)·2^(4+S) clock cycles, where P is the prescaler field and S the divide select field.
- R6: On each tick the counter decrements by one; a tick that finds it at zero is an expiry and reloads the counter from the reload register, so a counter started at N expires on tick N+1.
- R7: An expiry drives the reset output high for exactly 4 clock cycles, starting the cycle after the expiring tick, only when both run and reset-arm are 1; with reset-arm 0 no pulse is produced.
- R8: With run at 0 the counter and both divider stages hold their values.
- R9: Writing 0 to control, then 1 to the counter, then 0x3 to control (run and reset-arm, fastest division) produces the reset pulse 32 clock cycles after the final write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, data follows next cycle |
| bus_addr | input | 4 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| wdt_reset_o | output | 1 | System reset pulse, active high |

## Verification
The bench builds the block with its default parameters: 8-bit prescaler, 2-bit divide select starting at divide-by-16, 16-bit counter and a 4-cycle pulse. With these values the shortest tick is 16 cycles and the longest combination tried is 384 cycles, so timeouts from one tick up to several ticks across all four divide selects can be timed to the exact cycle in a few thousand cycles, while the slowest setting (32768 cycles per tick) lets a counter write be read back with no tick in between.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 4;
  localparam int PSC_W    = 8;
  localparam int SEL_W    = 2;
  localparam int CNT_W    = 16;
  localparam int DIV_BASE = 4;
  localparam int PULSE_LEN = 4;

  // control bit positions
  localparam int RUN_BIT  = 0;
  localparam int ARM_BIT  = 1;
  localparam int SEL_LSB  = 4;
  localparam int PSC_LSB  = 8;

  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 4'h0;
  localparam logic [ADDR_W-1:0] ADDR_RELOAD = 4'h4;
  localparam logic [ADDR_W-1:0] ADDR_COUNT  = 4'h8;

  typedef enum logic [1:0] {
    SEL_CTRL,
    SEL_RELOAD,
    SEL_COUNT,
    SEL_NONE
  } reg_sel_e;

  typedef struct packed {
    logic [PSC_W-1:0] pre_div;
    logic [SEL_W-1:0] div_sel;
    logic             rst_arm;
    logic             run;
  } wd_ctrl_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [CNT_W-1:0]  cnt_val,
  output wd_ctrl_t          ctrl_q,
  output logic [CNT_W-1:0]  reload_q,
  output logic              cnt_wr,
  output logic [CNT_W-1:0]  cnt_wdata,
  output logic [DATA_W-1:0] bus_rdata
);
  reg_sel_e          sel;
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    unique case (bus_addr)
      ADDR_CTRL:   sel = SEL_CTRL;
      ADDR_RELOAD: sel = SEL_RELOAD;
      ADDR_COUNT:  sel = SEL_COUNT;
      default:     sel = SEL_NONE;
    endcase
  end

  assign cnt_wr    = bus_wr && (sel == SEL_COUNT);
  assign cnt_wdata = bus_wdata[CNT_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      reload_q <= '1;
    end else if (bus_wr) begin
      if (sel == SEL_CTRL) begin
        ctrl_q.run     <= bus_wdata[RUN_BIT];
        ctrl_q.rst_arm <= bus_wdata[ARM_BIT];
        ctrl_q.div_sel <= bus_wdata[SEL_LSB +: SEL_W];
        ctrl_q.pre_div <= bus_wdata[PSC_LSB +: PSC_W];
      end
      if (sel == SEL_RELOAD && !ctrl_q.run)
        reload_q <= bus_wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (sel)
      SEL_CTRL: begin
        rd_mux[RUN_BIT]             = ctrl_q.run;
        rd_mux[ARM_BIT]             = ctrl_q.rst_arm;
        rd_mux[SEL_LSB +: SEL_W]    = ctrl_q.div_sel;
        rd_mux[PSC_LSB +: PSC_W]    = ctrl_q.pre_div;
      end
      SEL_RELOAD: rd_mux[CNT_W-1:0] = reload_q;
      SEL_COUNT:  rd_mux[CNT_W-1:0] = cnt_val;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  AST_RELOAD_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && sel == SEL_RELOAD && ctrl_q.run) |=> $stable(reload_q)); // R3
  AST_CTRL_RUN_WRITE: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && sel == SEL_CTRL) |=> (ctrl_q.run == $past(bus_wdata[RUN_BIT]))); // R2
endmodule

// File: rtl/wdog_clkdiv.sv
module wdog_clkdiv
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [PSC_W-1:0] pre_div,
  input  logic [SEL_W-1:0] div_sel,
  output logic             tick
);
  localparam int POST_W = DIV_BASE + (1 << SEL_W) - 1;

  logic [PSC_W-1:0]  pre_cnt;
  logic [POST_W-1:0] post_cnt;
  logic [POST_W:0]   span;
  logic [POST_W-1:0] mask;
  logic              pre_tick;

  always_comb begin
    span = ({{POST_W{1'b0}}, 1'b1} << (DIV_BASE + int'(div_sel))) - 1'b1;
    mask = span[POST_W-1:0];
  end

  assign pre_tick = run && (pre_cnt == pre_div);
  assign tick     = pre_tick && ((post_cnt & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_cnt  <= '0;
      post_cnt <= '0;
    end else if (run) begin
      pre_cnt <= pre_tick ? '0 : pre_cnt + 1'b1;
      if (pre_tick) post_cnt <= post_cnt + 1'b1;
    end
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick); // R5
  AST_DIV_HOLD: assert property (@(posedge clk) disable iff (rst)
    !run |=> ($stable(pre_cnt) && $stable(post_cnt))); // R8
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic             load_wr,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  assign expire = tick && !load_wr && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '1;
    else if (load_wr)     cnt <= load_val;
    else if (tick) begin
      if (cnt == '0)      cnt <= reload;
      else                cnt <= cnt - 1'b1;
    end
  end

  AST_LOAD_DIRECT: assert property (@(posedge clk) disable iff (rst)
    load_wr |=> (cnt == $past(load_val))); // R4
  AST_COUNT_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!run && !load_wr) |=> $stable(cnt)); // R8
  AST_DECREMENT: assert property (@(posedge clk) disable iff (rst)
    (tick && !load_wr && cnt != '0) |=> (cnt == CNT_W'($past(cnt) - 1'b1))); // R6
  AST_EXPIRY_RELOAD: assert property (@(posedge clk) disable iff (rst)
    expire |=> (cnt == $past(reload))); // R6
endmodule

// File: rtl/wdog_rstgen.sv
module wdog_rstgen
  import wdog_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic rst_o
);
  localparam int LEN_W = $clog2(PULSE_LEN + 1);

  logic [LEN_W-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      left  <= '0;
      rst_o <= 1'b0;
    end else if (fire) begin
      left  <= LEN_W'(PULSE_LEN);
      rst_o <= 1'b1;
    end else begin
      if (left != '0) left <= left - 1'b1;
      rst_o <= (left > LEN_W'(1));
    end
  end

  AST_PULSE_HOLD: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_o) |=> rst_o); // R7
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              wdt_reset_o
);
  wd_ctrl_t         ctrl_q;
  logic [CNT_W-1:0] reload_q;
  logic [CNT_W-1:0] cnt_val;
  logic [CNT_W-1:0] cnt_wdata;
  logic             cnt_wr;
  logic             tick;
  logic             expire;
  logic             fire;

  wdog_regs u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .cnt_val   (cnt_val),
    .ctrl_q    (ctrl_q),
    .reload_q  (reload_q),
    .cnt_wr    (cnt_wr),
    .cnt_wdata (cnt_wdata),
    .bus_rdata (bus_rdata)
  );

  wdog_clkdiv u_div (
    .clk     (clk),
    .rst     (rst),
    .run     (ctrl_q.run),
    .pre_div (ctrl_q.pre_div),
    .div_sel (ctrl_q.div_sel),
    .tick    (tick)
  );

  wdog_counter u_cnt (
    .clk      (clk),
    .rst      (rst),
    .run      (ctrl_q.run),
    .tick     (tick),
    .load_wr  (cnt_wr),
    .load_val (cnt_wdata),
    .reload   (reload_q),
    .cnt      (cnt_val),
    .expire   (expire)
  );

  assign fire = expire && ctrl_q.run && ctrl_q.rst_arm;

  wdog_rstgen u_rst (
    .clk   (clk),
    .rst   (rst),
    .fire  (fire),
    .rst_o (wdt_reset_o)
  );

  AST_ARMED_ONLY: assert property (@(posedge clk) disable iff (rst)
    $rose(wdt_reset_o) |-> $past(ctrl_q.run && ctrl_q.rst_arm && tick)); // R7
endmodule

// File: tb/wdog_timer_tb_top.sv
module wdog_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 5;
  // vector: {prescaler[7:0], divide select[1:0], start count[15:0]}
  localparam logic [25:0] VEC [NVEC] = '{
    {8'd0, 2'd0, 16'd3},
    {8'd1, 2'd1, 16'd2},
    {8'd2, 2'd3, 16'd1},
    {8'd4, 2'd2, 16'd0},
    {8'd0, 2'd3, 16'd5}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wdt_reset_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_timer dut_i (
    .clk         (clk),
    .rst         (rst),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .wdt_reset_o (wdt_reset_o)
  );

  function automatic logic [31:0] ctrl_word(bit run, bit arm, logic [1:0] s, logic [7:0] p);
    return {16'h0, p, 2'b00, s, 2'b00, arm, run};
  endfunction

  task automatic chk(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic hard_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1; bus_wr = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(posedge clk); #1; bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic wait_pulse(int limit, output int n);
    n = 0;
    while (!wdt_reset_o && n < limit) begin
      @(posedge clk); #1; n++;
    end
  endtask

  task automatic pulse_len(output int hi);
    hi = 0;
    while (wdt_reset_o && hi < 50) begin
      hi++; @(posedge clk); #1;
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    logic [31:0] d;
    int n, hi;
    hard_reset();

    // R1 reset values
    chk("R1 reset out", wdt_reset_o, 0);
    rd(4'h0, d); chk("R1 ctrl", d, 32'h0);
    rd(4'h4, d); chk("R1 reload", d, 32'hFFFF);
    rd(4'h8, d); chk("R1 count", d, 32'hFFFF);

    // R2 field layout and masking
    wr(4'h0, 32'h0000_AB32); rd(4'h0, d); chk("R2 ctrl fields", d, 32'h0000_AB32);
    wr(4'h0, 32'hFFFF_FFFE); rd(4'h0, d); chk("R2 ctrl mask", d, 32'h0000_FF32);

    // R5 R6 R7 table of timing vectors
    for (int i = 0; i < NVEC; i++) begin
      logic [7:0] p = VEC[i][25:18];
      logic [1:0] s = VEC[i][17:16];
      logic [15:0] c = VEC[i][15:0];
      int expect_n = (int'(c) + 1) * (int'(p) + 1) * (16 << s);
      hard_reset();
      wr(4'h8, {16'h0, c});
      wr(4'h0, ctrl_word(1, 1, s, p));
      wait_pulse(expect_n + 20, n);
      chk($sformatf("R5 R6 timeout vec %0d", i), n, expect_n);
      pulse_len(hi);
      chk($sformatf("R7 pulse width vec %0d", i), hi, 4);
    end

    // R3 reload write lock
    hard_reset();
    wr(4'h4, 32'h10);
    wr(4'h0, ctrl_word(1, 0, 2'd3, 8'hFF));
    wr(4'h4, 32'h77);
    rd(4'h4, d); chk("R3 locked reload", d, 32'h10);
    wr(4'h0, 32'h0);
    wr(4'h4, 32'h77);
    rd(4'h4, d); chk("R3 unlocked reload", d, 32'h77);

    // R4 direct load while running
    hard_reset();
    wr(4'h0, ctrl_word(1, 0, 2'd3, 8'hFF));
    wr(4'h8, 32'h1234);
    rd(4'h8, d); chk("R4 counter load", d, 32'h1234);

    // R8 freeze
    hard_reset();
    wr(4'h8, 32'h5);
    wr(4'h0, ctrl_word(1, 0, 2'd0, 8'd0));
    repeat (40) @(posedge clk);
    wr(4'h0, 32'h0);
    rd(4'h8, d); chk("R8 count at stop", d, 32'h3);
    repeat (100) @(posedge clk);
    rd(4'h8, d); chk("R8 count frozen", d, 32'h3);

    // R6 reload on expiry, R7 no pulse when not armed
    hard_reset();
    wr(4'h4, 32'h2);
    wr(4'h8, 32'h0);
    wr(4'h0, ctrl_word(1, 0, 2'd0, 8'd0));
    repeat (20) @(posedge clk);
    rd(4'h8, d); chk("R6 reload after expiry", d, 32'h2);
    wait_pulse(100, n);
    chk("R7 no pulse unarmed", wdt_reset_o, 0);

    // R9 quick-fire sequence
    hard_reset();
    wr(4'h0, 32'h0);
    wr(4'h8, 32'h1);
    wr(4'h0, 32'h3);
    wait_pulse(100, n);
    chk("R9 quick reset delay", n, 32);
    pulse_len(hi);
    chk("R9 quick reset width", hi, 4);

    done = 1'b1;
    summary();
  end
endmodule